// File: doc/BRIEF.md
# Selectable Four-Digit Scanned Time Display

This block turns a ten-digit elapsed time (tens and units of days, hours, minutes, seconds and centiseconds, each a BCD digit) into drive signals for a four-digit, time-multiplexed seven-segment display. The digits share a common anode, so segments and digit enables are both active low.

A two-bit range select picks a window of four adjacent digits: two digits for one unit on the left and two for the next finer unit on the right. A decimal point marks the boundary between the two units. A one-cycle scan enable, which a clock divider outside the block sets to 10 kHz, moves the scan one digit to the right on each pulse. The scan wraps after the rightmost digit, so each digit is lit for 100 µs in every 400 µs frame. Both outputs are registered.

Top module: `tscan_disp`

## Requirements
- R1: A clock edge that samples `rst` high sets `seg_n` to 8'hFF (all dark) and `dig_en_n` to 4'b0111, and returns the scan to the leftmost position. After release, scanning starts from the leftmost digit.
- R2: `dig_en_n` is active low and has exactly one bit low at every edge after reset.
- R3: Bit 3 of `dig_en_n` drives the leftmost digit and bit 0 the rightmost. The scan position advances by one at each edge that samples `scan_tick` high, and wraps from the rightmost digit back to the leftmost. The outputs show a new position at the edge after the one that moved it.
- R4: While `scan_tick` stays low, the lit digit does not change.
- R5: With `range_sel` = 2'b00, the digits from left to right are seconds tens, seconds units, centiseconds tens and centiseconds units.
- R6: With `range_sel` = 2'b01, the digits are minutes tens/units and then seconds tens/units. With 2'b10 they are hours tens/units and then minutes tens/units. With 2'b11 they are days tens/units and then hours tens/units.
- R7: `seg_n[6:0]` carries segments g,f,e,d,c,b,a (bit 6 = g) and is active low. The lit-segment patterns (active high, g..a) for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: A digit code from 10 to 15 shows no segment lit (`seg_n[6:0]` = 7'h7F).
- R9: `seg_n[7]` is the decimal point, active low. It is lit only while the second digit from the left is enabled.
- R10: A change to `range_sel` or to any digit input shows on the next output update, and the scan position is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle pulse that advances the scan |
| range_sel | input | 2 | Selects which four time digits are shown |
| day_tens | input | 4 | Days, tens digit (BCD) |
| day_ones | input | 4 | Days, units digit |
| hr_tens | input | 4 | Hours, tens digit |
| hr_ones | input | 4 | Hours, units digit |
| min_tens | input | 4 | Minutes, tens digit |
| min_ones | input | 4 | Minutes, units digit |
| sec_tens | input | 4 | Seconds, tens digit |
| sec_ones | input | 4 | Seconds, units digit |
| cs_tens | input | 4 | Centiseconds, tens digit |
| cs_ones | input | 4 | Centiseconds, units digit |
| seg_n | output | 8 | Segments dp,g,f,e,d,c,b,a (bit 7 to bit 0), active low |
| dig_en_n | output | 4 | Digit enables, active low, bit 3 = leftmost |

## Verification
A scan advance and a change of range or digit value can fall on the same clock edge. The bench provokes this by changing `range_sel` and the digit inputs in cycles that also carry `scan_tick`. It expects the output at the next edge to show the new window and value at the old position, and the move to the next position one edge later. A reset can also coincide with a scan pulse. The bench asserts both together and expects the reset to win: the display is blanked and the scan returns to the leftmost digit.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  localparam int DIG_W    = 4;
  localparam int NUM_DIG  = 4;
  localparam int NUM_SRC  = 10;
  localparam int SEG_W    = 8;
  localparam int RSEL_W   = 2;
  localparam int POS_W    = $clog2(NUM_DIG);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int BASE_MAX = NUM_SRC - NUM_DIG;
  localparam int DP_POS   = NUM_DIG / 2 - 1;

  typedef logic [DIG_W-1:0] bcd_t;

  // Active-high segment pattern, bit 6 = g down to bit 0 = a.
  function automatic logic [6:0] bcd_to_seg(bcd_t d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/tscan_pos.sv
module tscan_pos
  import tscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(NUM_DIG - 1);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (step)
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/tscan_window.sv
module tscan_window
  import tscan_pkg::*;
(
  input  logic [RSEL_W-1:0] range_sel,
  input  logic [POS_W-1:0]  pos,
  input  bcd_t              src [NUM_SRC],
  output bcd_t              digit
);
  bcd_t slot [NUM_DIG];

  // src[0] is the most significant time digit. Range 3 starts at 0, range 0 at BASE_MAX.
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_slot
    logic [IDX_W-1:0] idx;
    assign idx     = IDX_W'(BASE_MAX + g) - IDX_W'({range_sel, 1'b0});
    assign slot[g] = src[idx];
  end

  assign digit = slot[pos];
endmodule

// File: rtl/tscan_seg.sv
module tscan_seg
  import tscan_pkg::*;
(
  input  bcd_t             digit,
  input  logic             dp_on,
  output logic [SEG_W-1:0] seg_n
);
  assign seg_n = {~dp_on, ~bcd_to_seg(digit)};
endmodule

// File: rtl/tscan_disp.sv
module tscan_disp
  import tscan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scan_tick,
  input  logic [RSEL_W-1:0]  range_sel,
  input  logic [DIG_W-1:0]   day_tens,
  input  logic [DIG_W-1:0]   day_ones,
  input  logic [DIG_W-1:0]   hr_tens,
  input  logic [DIG_W-1:0]   hr_ones,
  input  logic [DIG_W-1:0]   min_tens,
  input  logic [DIG_W-1:0]   min_ones,
  input  logic [DIG_W-1:0]   sec_tens,
  input  logic [DIG_W-1:0]   sec_ones,
  input  logic [DIG_W-1:0]   cs_tens,
  input  logic [DIG_W-1:0]   cs_ones,
  output logic [SEG_W-1:0]   seg_n,
  output logic [NUM_DIG-1:0] dig_en_n
);
  localparam logic [NUM_DIG-1:0] LEFT_ONE = {1'b1, {(NUM_DIG-1){1'b0}}};

  bcd_t             src [NUM_SRC];
  logic [POS_W-1:0] pos;
  bcd_t             digit;
  logic [SEG_W-1:0] seg_c;
  logic             dp_on;

  assign src[0] = day_tens;
  assign src[1] = day_ones;
  assign src[2] = hr_tens;
  assign src[3] = hr_ones;
  assign src[4] = min_tens;
  assign src[5] = min_ones;
  assign src[6] = sec_tens;
  assign src[7] = sec_ones;
  assign src[8] = cs_tens;
  assign src[9] = cs_ones;

  tscan_pos u_pos (
    .clk  (clk),
    .rst  (rst),
    .step (scan_tick),
    .pos  (pos)
  );

  tscan_window u_win (
    .range_sel (range_sel),
    .pos       (pos),
    .src       (src),
    .digit     (digit)
  );

  assign dp_on = (pos == POS_W'(DP_POS));

  tscan_seg u_seg (
    .digit (digit),
    .dp_on (dp_on),
    .seg_n (seg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n    <= '1;
      dig_en_n <= ~LEFT_ONE;
    end else begin
      seg_n    <= seg_c;
      dig_en_n <= ~(LEFT_ONE >> pos);
    end
  end
endmodule

// File: rtl/tscan_chk.sv
module tscan_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] seg_n,
  input logic [3:0] dig_en_n
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: the edge after a reset edge shows dark segments and the leftmost enable.
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_blank_r1: assert (seg_n == 8'hFF && dig_en_n == 4'b0111)
        else $error("reset state wrong");
    end
  end

  p_one_enable_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_en_n) == 1);

  p_scan_order_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dig_en_n) |-> dig_en_n == {$past(dig_en_n[0]), $past(dig_en_n[3:1])});

  p_dp_second_r9: assert property (@(posedge clk) disable iff (rst)
    seg_n[7] == (dig_en_n != 4'b1011));
endmodule

bind tscan_disp tscan_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .seg_n    (seg_n),
  .dig_en_n (dig_en_n)
);

// File: tb/test_tscan_disp.sv
module test_tscan_disp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] rng = 2'b00;
  logic [3:0] dg [10];
  logic [7:0] seg_n;
  logic [3:0] dig_en_n;

  always #4 clk = ~clk;

  tscan_disp i_tscan_disp (
    .clk (clk), .rst (rst), .scan_tick (tick), .range_sel (rng),
    .day_tens (dg[0]), .day_ones (dg[1]), .hr_tens (dg[2]), .hr_ones (dg[3]),
    .min_tens (dg[4]), .min_ones (dg[5]), .sec_tens (dg[6]), .sec_ones (dg[7]),
    .cs_tens (dg[8]), .cs_ones (dg[9]),
    .seg_n (seg_n), .dig_en_n (dig_en_n)
  );

  int m_pos = 0;
  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] e_seg;
  logic [3:0] e_en;

  function automatic logic [6:0] lit(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic step(string tag);
    int first;
    @(posedge clk);
    if (rst) begin
      e_seg = 8'hFF; e_en = 4'b0111; m_pos = 0;
    end else begin
      first = 6 - 2 * int'(rng);
      e_en  = ~(4'b1000 >> m_pos);
      e_seg = {(m_pos != 1), ~lit(int'(dg[first + m_pos]))};
      if (tick) m_pos = (m_pos + 1) % 4;
    end
    @(negedge clk);
    vecs++;
    if (dig_en_n !== e_en) begin
      bad++;
      $display("FAIL %s enables: got %b expected %b", tag, dig_en_n, e_en);
    end
    if (seg_n !== e_seg) begin
      bad++;
      $display("FAIL %s segments: got %h expected %h", tag, seg_n, e_seg);
    end
  endtask

  initial begin
    for (int k = 0; k < 10; k++) dg[k] = 4'((k * 3 + 1) % 10);
    repeat (3) step("R1");
    rst = 1'b0;
    repeat (5) step("R4");                       // no tick: position holds
    for (int i = 0; i < 20; i++) begin           // R5 window, slow scan
      tick = (i % 3 == 0);
      step("R5 R7 R9");
    end
    for (int r = 1; r < 4; r++) begin            // R6 windows, scan each cycle
      rng = 2'(r);
      for (int i = 0; i < 12; i++) begin
        tick = 1'b1;
        step("R6 R3 R2");
      end
    end
    rng = 2'b00;                                 // R8 non-BCD codes
    for (int v = 10; v < 16; v++) begin
      for (int k = 6; k < 10; k++) dg[k] = 4'(v);
      for (int i = 0; i < 5; i++) begin
        tick = 1'b1;
        step("R8");
      end
    end
    for (int i = 0; i < 24; i++) begin           // R10 change with tick
      tick = (i % 2 == 0);
      rng  = 2'((i / 3) % 4);
      for (int k = 0; k < 10; k++) dg[k] = 4'((k + i) % 10);
      step("R10");
    end
    tick = 1'b1; rst = 1'b1;                     // R1 reset over a tick
    repeat (2) step("R1");
    rst = 1'b0; tick = 1'b0;
    repeat (3) step("R1");
    for (int i = 0; i < 10; i++) begin
      tick = 1'b1;
      step("R3");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R3 watchdog expired: got hang expected end");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule